// File: doc/BRIEF.md
# Interrupt Priority Threshold Filter

This block sits between the interrupt request lines of a processor core and its trap-entry logic. Fifteen level-sensitive request lines, one per priority level 1 to 15, are compared against a programmable 4-bit priority threshold register and a global interrupt enable. Of the requests that pass, the block offers the highest one to the trap-entry logic. It presents the level together with an 8-bit trap type derived from that level.

Sixteen priority levels exist, 0 to 15, and 15 is the most urgent. A request passes only when its level is strictly above the threshold, so a threshold of 0 lets every level through and a threshold of 15 blocks all of them. The threshold changes only through a write port that is honoured in privileged mode. The offer is level-sensitive and follows the current inputs. It stays up until the trap-entry logic acknowledges it. After an acknowledge the offer drops for one cycle, which gives the trap-entry logic time to raise the threshold or clear the enable. The acknowledge never clears the requests themselves.

Top module: `pil_filter`

## Requirements
- R1: After reset the threshold register reads 15 on `pilLevel`, and `takeReq` is low.
- R2: Bit L-1 of `irqPending` is the request of level L (1 to 15). With the enable set and a threshold of 0, a request of any level is offered on `takeReq` and `takeLevel` in the same cycle it is applied.
- R3: A request whose level is less than or equal to the threshold is never offered.
- R4: While `intEnable` is low, `takeReq` is low whatever requests are pending.
- R5: When several allowed requests are pending, `takeLevel` is the highest of their levels.
- R6: `takeTrapType` equals 0x40 plus `takeLevel`, so levels 1 to 15 give 0x41 to 0x4F.
- R7: A threshold write with `pilWrEn` and `privMode` both high at a clock edge loads `pilWrData` into the register, and the new value is visible on `pilLevel` from the next cycle. A write with `privMode` low leaves the register unchanged.
- R8: While an offer is allowed and not acknowledged, `takeReq` stays high. A cycle with `takeReq` and `takeAck` both high is followed by exactly one cycle with `takeReq` low. The offer then reappears if the request is still pending and allowed, since the acknowledge does not clear requests.
- R9: From the cycle after a threshold write, a request that the new threshold no longer allows is not offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqPending | input | 15 | Level-sensitive requests; bit L-1 is level L |
| intEnable | input | 1 | Global interrupt enable |
| privMode | input | 1 | High when the writer is privileged |
| pilWrEn | input | 1 | Threshold write strobe |
| pilWrData | input | 4 | New threshold value |
| takeAck | input | 1 | Acknowledge from trap-entry logic |
| pilLevel | output | 4 | Current threshold register |
| takeReq | output | 1 | Interrupt offer to trap-entry logic |
| takeLevel | output | 4 | Level of the offered interrupt |
| takeTrapType | output | 8 | Trap type of the offered interrupt |

## Verification
Several properties are checked on every cycle. An offer is always above the threshold, has the enable set and matches a pending line, and no pending line is higher than the offered level. The trap type always tracks the level. An acknowledged offer is always followed by a one-cycle gap, and the threshold register changes only through a privileged write. The directed scenarios show the remaining behaviour. These cover the reset value, the selection among particular mixes of requests, the boundary where the level equals the threshold, an ignored unprivileged write, the re-offer after an acknowledge, and the withdrawal of a pending offer right after a threshold raise.

// File: rtl/pil_filter_pkg.sv
package pil_filter_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic pilLoad;  // load the threshold register at this edge
    logic offerEn;  // offers may be shown this cycle
  } pil_strobe_t;

endpackage

// File: rtl/pil_filter_datapath.sv
module pil_filter_datapath
  import pil_filter_pkg::*;
#(
  parameter int LevelWidth = 4,
  parameter int TrapWidth  = 8,
  parameter int TrapBase   = 'h40,
  localparam int NumReq    = (2 ** LevelWidth) - 1,
  localparam int MaxLevel  = NumReq
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NumReq-1:0]     irqPending,
  input  logic                  intEnable,
  input  logic [LevelWidth-1:0] pilWrData,
  input  pil_strobe_t           strobes,
  output logic [LevelWidth-1:0] pilLevel,
  output logic                  takeReq,
  output logic [LevelWidth-1:0] takeLevel,
  output logic [TrapWidth-1:0]  takeTrapType
);

  logic [LevelWidth-1:0] pilReg;
  logic [NumReq-1:0]     allowed;
  logic                  candValid;
  logic [LevelWidth-1:0] candLevel;

  // Threshold register, reset to the most restrictive value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pilReg <= LevelWidth'(MaxLevel);
    end else if (strobes.pilLoad) begin
      pilReg <= pilWrData;
    end
  end

  // Per-level gate: strictly above threshold and globally enabled
  for (genvar lvl = 0; lvl < NumReq; lvl++) begin : gLevelGate
    assign allowed[lvl] = irqPending[lvl] && intEnable &&
                          (LevelWidth'(lvl + 1) > pilReg);
  end

  // Priority encoder: the highest allowed level wins
  always_comb begin
    candValid = 1'b0;
    candLevel = '0;
    for (int i = 0; i < NumReq; i++) begin
      if (allowed[i]) begin
        candValid = 1'b1;
        candLevel = LevelWidth'(i + 1);
      end
    end
  end

  assign pilLevel     = pilReg;
  assign takeReq      = candValid && strobes.offerEn;
  assign takeLevel    = candLevel;
  assign takeTrapType = TrapWidth'(TrapBase) + TrapWidth'(candLevel);

endmodule

// File: rtl/pil_filter_control.sv
module pil_filter_control
  import pil_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pilWrEn,
  input  logic        privMode,
  input  logic        takeReq,
  input  logic        takeAck,
  output pil_strobe_t strobes
);

  logic holdOff;

  // One quiet cycle after each accepted acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdOff <= 1'b0;
    end else begin
      holdOff <= takeReq && takeAck;
    end
  end

  always_comb begin
    strobes.pilLoad = pilWrEn && privMode;
    strobes.offerEn = !holdOff;
  end

endmodule

// File: rtl/pil_filter.sv
module pil_filter
  import pil_filter_pkg::*;
#(
  parameter int LevelWidth = 4,
  parameter int TrapWidth  = 8,
  parameter int TrapBase   = 'h40,
  localparam int NumReq    = (2 ** LevelWidth) - 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NumReq-1:0]     irqPending,
  input  logic                  intEnable,
  input  logic                  privMode,
  input  logic                  pilWrEn,
  input  logic [LevelWidth-1:0] pilWrData,
  input  logic                  takeAck,
  output logic [LevelWidth-1:0] pilLevel,
  output logic                  takeReq,
  output logic [LevelWidth-1:0] takeLevel,
  output logic [TrapWidth-1:0]  takeTrapType
);

  pil_strobe_t strobes;

  pil_filter_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .pilWrEn  (pilWrEn),
    .privMode (privMode),
    .takeReq  (takeReq),
    .takeAck  (takeAck),
    .strobes  (strobes)
  );

  pil_filter_datapath #(
    .LevelWidth (LevelWidth),
    .TrapWidth  (TrapWidth),
    .TrapBase   (TrapBase)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .irqPending   (irqPending),
    .intEnable    (intEnable),
    .pilWrData    (pilWrData),
    .strobes      (strobes),
    .pilLevel     (pilLevel),
    .takeReq      (takeReq),
    .takeLevel    (takeLevel),
    .takeTrapType (takeTrapType)
  );

endmodule

// File: rtl/pil_filter_checker.sv
module pil_filter_checker #(
  parameter int LevelWidth = 4,
  parameter int TrapWidth  = 8,
  localparam int NumReq    = (2 ** LevelWidth) - 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NumReq-1:0]     irqPending,
  input logic                  intEnable,
  input logic                  privMode,
  input logic                  pilWrEn,
  input logic [LevelWidth-1:0] pilWrData,
  input logic                  takeAck,
  input logic [LevelWidth-1:0] pilLevel,
  input logic                  takeReq,
  input logic [LevelWidth-1:0] takeLevel,
  input logic [TrapWidth-1:0]  takeTrapType
);

  AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> (takeLevel != '0) && irqPending[takeLevel - 1'b1]); // R2

  AST_TAKE_ABOVE_PIL: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> takeLevel > pilLevel); // R3

  AST_TAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> intEnable); // R4

  AST_NO_HIGHER_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> (irqPending >> takeLevel) == '0); // R5

  AST_TRAP_TYPE: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> takeTrapType == 8'h40 + {4'h0, takeLevel}); // R6

  AST_PIL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (pilWrEn && privMode) |=> pilLevel == $past(pilWrData)); // R7

  AST_PIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(pilWrEn && privMode) |=> $stable(pilLevel)); // R7

  AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && takeAck) |=> !takeReq); // R8

endmodule

bind pil_filter pil_filter_checker #(
  .LevelWidth (LevelWidth),
  .TrapWidth  (TrapWidth)
) uChecker (.*);

// File: tb/tb_pil_filter.sv
module tb_pil_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] irqPending = '0;
  logic        intEnable = 1'b0;
  logic        privMode = 1'b0;
  logic        pilWrEn = 1'b0;
  logic [3:0]  pilWrData = '0;
  logic        takeAck = 1'b0;
  logic [3:0]  pilLevel;
  logic        takeReq;
  logic [3:0]  takeLevel;
  logic [7:0]  takeTrapType;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pil_filter dut (
    .clk          (clk),
    .rstN         (rstN),
    .irqPending   (irqPending),
    .intEnable    (intEnable),
    .privMode     (privMode),
    .pilWrEn      (pilWrEn),
    .pilWrData    (pilWrData),
    .takeAck      (takeAck),
    .pilLevel     (pilLevel),
    .takeReq      (takeReq),
    .takeLevel    (takeLevel),
    .takeTrapType (takeTrapType)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] actual, input logic [31:0] expected);
    testsRun++;
    if (actual !== expected) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
    end
  endtask

  // Inputs change just after a falling edge; outputs are sampled 1 ns later
  task automatic stepAndSettle();
    @(negedge clk);
    #1;
  endtask

  task automatic writePil(input logic [3:0] value, input logic priv);
    @(negedge clk);
    pilWrEn = 1'b1; pilWrData = value; privMode = priv;
    @(negedge clk);
    pilWrEn = 1'b0; privMode = 1'b0;
    #1;
  endtask

  task automatic testReset();
    check("R1", "pil after reset", 32'(pilLevel), 32'd15);
    check("R1", "take after reset", 32'(takeReq), 32'd0);
  endtask

  task automatic testAllowAll();
    writePil(4'd0, 1'b1);
    @(negedge clk);
    intEnable = 1'b1; irqPending = 15'b1;  // level 1
    #1;
    check("R2", "take level 1 at pil 0", 32'(takeReq), 32'd1);
    check("R2", "level 1 reported", 32'(takeLevel), 32'd1);
    check("R6", "trap type level 1", 32'(takeTrapType), 32'h41);
    @(negedge clk);
    irqPending = 15'h4000;  // level 15
    #1;
    check("R2", "level 15 reported", 32'(takeLevel), 32'd15);
    check("R6", "trap type level 15", 32'(takeTrapType), 32'h4F);
  endtask

  task automatic testPriority();
    @(negedge clk);
    irqPending = 15'b000_0010_0100_1001;  // levels 1, 4, 7, 10
    #1;
    check("R5", "highest of 1/4/7/10", 32'(takeLevel), 32'd10);
    @(negedge clk);
    irqPending = 15'b000_0000_0000_0110;  // levels 2, 3
    #1;
    check("R5", "highest of 2/3", 32'(takeLevel), 32'd3);
    check("R6", "trap type level 3", 32'(takeTrapType), 32'h43);
  endtask

  task automatic testThreshold();
    writePil(4'd6, 1'b1);
    check("R7", "pil after privileged write", 32'(pilLevel), 32'd6);
    @(negedge clk);
    irqPending = 15'b000_0000_0010_0000;  // level 6 only, equal to pil
    #1;
    check("R3", "level equal to pil ignored", 32'(takeReq), 32'd0);
    @(negedge clk);
    irqPending = 15'b000_0000_0110_0000;  // levels 6 and 7
    #1;
    check("R3", "level 7 above pil 6 taken", 32'(takeReq), 32'd1);
    check("R3", "level 7 reported", 32'(takeLevel), 32'd7);
  endtask

  task automatic testEnable();
    @(negedge clk);
    intEnable = 1'b0; irqPending = 15'h7FFF;
    #1;
    check("R4", "no take with enable low", 32'(takeReq), 32'd0);
    stepAndSettle();
    check("R4", "still no take with enable low", 32'(takeReq), 32'd0);
    @(negedge clk);
    intEnable = 1'b1;
    #1;
    check("R4", "take after enable", 32'(takeLevel), 32'd15);
  endtask

  task automatic testUnprivWrite();
    writePil(4'd2, 1'b0);
    check("R7", "unprivileged write ignored", 32'(pilLevel), 32'd6);
    @(negedge clk);
    irqPending = 15'b000_0000_0000_0100;  // level 3, below pil 6
    #1;
    check("R7", "level 3 still masked by pil 6", 32'(takeReq), 32'd0);
  endtask

  task automatic testHandshake();
    writePil(4'd0, 1'b1);
    @(negedge clk);
    irqPending = 15'b000_0000_0001_0000;  // level 5
    #1;
    check("R8", "offer raised", 32'(takeReq), 32'd1);
    stepAndSettle();
    check("R8", "offer held without ack", 32'(takeReq), 32'd1);
    takeAck = 1'b1;
    @(negedge clk);
    takeAck = 1'b0;
    #1;
    check("R8", "offer low cycle after ack", 32'(takeReq), 32'd0);
    stepAndSettle();
    check("R8", "offer back, request not cleared", 32'(takeReq), 32'd1);
    check("R8", "re-offered level", 32'(takeLevel), 32'd5);
  endtask

  task automatic testWithdrawOnWrite();
    @(negedge clk);
    irqPending = 15'b000_0000_1000_0000;  // level 8
    pilWrEn = 1'b1; pilWrData = 4'd8; privMode = 1'b1;
    #1;
    check("R9", "level 8 offered before write", 32'(takeReq), 32'd1);
    @(negedge clk);
    pilWrEn = 1'b0; privMode = 1'b0;
    #1;
    check("R9", "level 8 withdrawn after pil 8", 32'(takeReq), 32'd0);
    @(negedge clk);
    irqPending = 15'b000_0001_1000_0000;  // levels 8 and 9
    #1;
    check("R9", "level 9 above new pil", 32'(takeLevel), 32'd9);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testAllowAll();
    testPriority();
    testThreshold();
    testEnable();
    testUnprivWrite();
    testHandshake();
    testWithdrawOnWrite();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule